// File: doc/BRIEF.md
# Burst ROM Read Sequencer

This block sits between a core-side request port and an external 16-bit ROM region. It turns each core request into one or more halfword bus beats. It drives the external halfword address, the chip enable and the read and write strobes. It captures the ROM data bus and returns the assembled 16-bit or 32-bit result with a single-cycle done pulse. Each request carries a byte address, a size flag, a write flag and a flag that marks it as an instruction fetch.

When the region is set up as burst ROM, reads run as page-style bursts. The first beat waits a programmed number of cycles (0 to 7), and every later beat of the same burst waits a separate, shorter count (0 to 3). The external wait input has no effect on these read beats. A run of contiguous fetches keeps the chip enable and the read strobe asserted and steps through the low address bits. The run stops at the top of a 4-halfword or 8-halfword group, or at the first fetch that is not the next halfword. Writes, and all accesses when burst mode is off, use plain SRAM-style beats. Those beats use the first-access wait and are stretched by the external wait input.

One request occupies the block at a time. A new request is taken while the block is idle. A fetch that continues the burst is also taken in the done cycle.

Top module: `brom_burst_seq`

## Requirements
- R1: After reset, ext_ce_no, ext_rd_no and ext_wr_no are high, ext_data_oe_o and rsp_done_o are low, and req_ready_o is high.
- R2: A request accepted from idle starts a beat in the next cycle. The first beat holds its address with chip enable and strobe low for cfg_first_wait_i + 1 cycles. Data is captured only on the edge that ends the last of those cycles.
- R3: With burst mode on, a 32-bit read is two beats at consecutive halfword addresses, and the second beat lasts cfg_beat_wait_i + 1 cycles. The halfword from the even address goes to rsp_data_o[15:0] and the one from the odd address to rsp_data_o[31:16]. A 16-bit read returns its halfword zero-extended.
- R4: During burst-mode reads the external wait input (ext_wait_ni low = wait) does not change the length of any beat.
- R5: A write is an SRAM-style beat with ext_wr_no low and the read strobe high. ext_data_o carries the low halfword of req_wdata_i first, then the high one for a 32-bit write. Each beat waits cfg_first_wait_i cycles and then holds as long as ext_wait_ni is low.
- R6: With burst mode on, a fetch presented in the done cycle of an earlier fetch is accepted there and continues the burst when its halfword address is the next one after the last beat. Its beats then use cfg_beat_wait_i, and chip enable and the read strobe stay low with no idle cycle.
- R7: A burst does not continue past a last beat whose halfword address bits [1:0] are 11 in 4-beat mode (cfg_burst8_i = 0), or whose bits [2:0] are 111 in 8-beat mode. The next fetch then starts a new first access.
- R8: A fetch that is not contiguous, or a request after a 32-bit data read or a write, is not accepted in the done cycle. The bus returns to idle for one cycle with chip enable released, and the request then starts with the first-access wait.
- R9: rsp_done_o is high for exactly one cycle, in the cycle after the final beat's capture edge. Chip enable is released in the following cycle unless a continuing fetch was accepted.
- R10: With burst mode off, every read beat uses cfg_first_wait_i, honours ext_wait_ni, and no fetch continues a burst.
- R11: While chip enable stays low, the halfword address bits above bit 2 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_burst_en_i | input | 1 | Region is burst ROM |
| cfg_burst8_i | input | 1 | 1: 8-beat group, 0: 4-beat group |
| cfg_first_wait_i | input | 3 | Wait cycles of a first or SRAM-style beat |
| cfg_beat_wait_i | input | 2 | Wait cycles of later burst beats |
| req_i | input | 1 | Request valid |
| req_we_i | input | 1 | Request is a write |
| req_word_i | input | 1 | 1: 32-bit access, 0: 16-bit access |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted this cycle when req_i is high |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | 32 | Read result, valid with rsp_done_o |
| ext_haddr_o | output | 23 | External halfword address |
| ext_ce_no | output | 1 | Chip enable, active low |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | 1 | Write strobe, active low |
| ext_wait_ni | input | 1 | External wait request, active low |
| ext_data_i | input | 16 | ROM data bus in |
| ext_data_o | output | 16 | Data bus out |
| ext_data_oe_o | output | 1 | Data bus output enable |

## Verification
The bench drives the ROM bus with junk in every cycle except the capture cycle. A design that samples one cycle early or late returns junk, and one that mixes up the two wait fields gets the beat lengths wrong. Fetch runs start on both sides of the 4-halfword and 8-halfword group edges. A design that misplaces the boundary either holds chip enable across a group or drops back to the first-access wait too soon. Burst reads hold the external wait input low the whole time, while writes and non-burst reads stretch on it. A design that honours the pin in the wrong place shows a beat that is too long or too short. Non-contiguous fetches, and fetches after 32-bit data reads, check that chip enable is released for an idle cycle rather than kept low.

// File: rtl/brom_pkg.sv
package brom_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_DONE} brom_st_e;
endpackage

// File: rtl/brom_wait_ctr.sv
module brom_wait_ctr #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/brom_page_ctl.sv
module brom_page_ctl #(
  parameter int HW = 23
) (
  input  logic [HW-1:0] last_h_i,
  input  logic          burst8_i,
  input  logic          burst_en_i,
  input  logic          last_rdb_i,
  input  logic          last_fetch_i,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic          req_fetch_i,
  input  logic          req_word_i,
  input  logic [HW-1:0] req_h_i,
  output logic          cont_o
);
  logic          at_edge;
  logic [HW-1:0] next_h;

  // group edge: 4-beat stops on x11, 8-beat on x111
  assign at_edge = burst8_i ? (&last_h_i[2:0]) : (&last_h_i[1:0]);
  assign next_h  = last_h_i + HW'(1);

  assign cont_o = burst_en_i && last_rdb_i && last_fetch_i && req_i && !req_we_i &&
                  req_fetch_i && !at_edge && (req_h_i == next_h) &&
                  !(req_word_i && req_h_i[0]);
endmodule

// File: rtl/brom_assemble.sv
module brom_assemble #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          hi_i,
  input  logic          word_i,
  input  logic [DW-1:0] data_i,
  output logic [2*DW-1:0] rsp_o
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cap_i) begin
      if (hi_i) hi_q <= data_i;
      else      lo_q <= data_i;
    end
  end

  assign rsp_o = word_i ? {hi_q, lo_q} : {{DW{1'b0}}, lo_q};
endmodule

// File: rtl/brom_burst_seq.sv
module brom_burst_seq #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int FWW = 3,
  parameter int BWW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_burst_en_i,
  input  logic            cfg_burst8_i,
  input  logic [FWW-1:0]  cfg_first_wait_i,
  input  logic [BWW-1:0]  cfg_beat_wait_i,
  input  logic            req_i,
  input  logic            req_we_i,
  input  logic            req_word_i,
  input  logic            req_fetch_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [2*DW-1:0] req_wdata_i,
  output logic            req_ready_o,
  output logic            rsp_done_o,
  output logic [2*DW-1:0] rsp_data_o,
  output logic [AW-2:0]   ext_haddr_o,
  output logic            ext_ce_no,
  output logic            ext_rd_no,
  output logic            ext_wr_no,
  input  logic            ext_wait_ni,
  input  logic [DW-1:0]   ext_data_i,
  output logic [DW-1:0]   ext_data_o,
  output logic            ext_data_oe_o
);
  import brom_pkg::*;

  localparam int HW = AW - 1;
  localparam int CW = (FWW > BWW) ? FWW : BWW;

  brom_st_e        st_q;
  logic [HW-1:0]   haddr_q, req_h;
  logic            we_q, fetch_q, word_q, hi_q, rdb_q;
  logic [2*DW-1:0] wdata_q;
  logic            cont, accept, cnt_zero, beat_end, more, load;
  logic [CW-1:0]   fw_ext, bw_ext, load_val;
  logic            unused_lsb;

  assign unused_lsb = req_addr_i[0];
  assign fw_ext     = CW'(cfg_first_wait_i);
  assign bw_ext     = CW'(cfg_beat_wait_i);
  assign req_h      = req_addr_i[AW-1:1];

  brom_page_ctl #(.HW(HW)) u_page (
    .last_h_i     (haddr_q),
    .burst8_i     (cfg_burst8_i),
    .burst_en_i   (cfg_burst_en_i),
    .last_rdb_i   (rdb_q),
    .last_fetch_i (fetch_q),
    .req_i        (req_i),
    .req_we_i     (req_we_i),
    .req_fetch_i  (req_fetch_i),
    .req_word_i   (req_word_i),
    .req_h_i      (req_h),
    .cont_o       (cont)
  );

  assign req_ready_o = (st_q == ST_IDLE) || ((st_q == ST_DONE) && cont);
  assign accept      = req_i && req_ready_o;
  // burst reads ignore the wait pin, everything else honours it
  assign beat_end    = (st_q == ST_BEAT) && cnt_zero && (rdb_q || ext_wait_ni);
  assign more        = word_q && !hi_q;
  assign load        = accept || (beat_end && more);
  assign load_val    = ((st_q == ST_IDLE) || !rdb_q) ? fw_ext : bw_ext;

  brom_wait_ctr #(.W(CW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      haddr_q <= '0;
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      word_q  <= 1'b0;
      hi_q    <= 1'b0;
      rdb_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            st_q    <= ST_BEAT;
            haddr_q <= req_word_i ? {req_h[HW-1:1], 1'b0} : req_h;
            we_q    <= req_we_i;
            fetch_q <= req_fetch_i;
            word_q  <= req_word_i;
            hi_q    <= 1'b0;
            rdb_q   <= cfg_burst_en_i && !req_we_i;
            wdata_q <= req_wdata_i;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_BEAT: begin
          if (beat_end) begin
            if (more) begin
              hi_q    <= 1'b1;
              haddr_q <= haddr_q + HW'(1);
            end else begin
              st_q <= ST_DONE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  brom_assemble #(.DW(DW)) u_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (beat_end && !we_q),
    .hi_i   (hi_q),
    .word_i (word_q),
    .data_i (ext_data_i),
    .rsp_o  (rsp_data_o)
  );

  assign rsp_done_o    = (st_q == ST_DONE);
  assign ext_haddr_o   = haddr_q;
  assign ext_ce_no     = (st_q == ST_IDLE);
  assign ext_rd_no     = !((st_q != ST_IDLE) && !we_q);
  assign ext_wr_no     = !((st_q == ST_BEAT) && we_q);
  assign ext_data_oe_o = (st_q == ST_BEAT) && we_q;
  assign ext_data_o    = hi_q ? wdata_q[2*DW-1:DW] : wdata_q[DW-1:0];
endmodule

// File: rtl/brom_burst_seq_chk.sv
module brom_burst_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          req_ready_o,
  input logic          rsp_done_o,
  input logic [AW-2:0] ext_haddr_o,
  input logic          ext_ce_no,
  input logic          ext_rd_no,
  input logic          ext_wr_no
);
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !(req_i && req_ready_o)) |=> ext_ce_no);

  assert_page_fixed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_ce_no |=> (ext_ce_no || $stable(ext_haddr_o[AW-2:3])));

  assert_cont_in_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && req_ready_o && !ext_ce_no) |-> rsp_done_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_no || ext_wr_no);

  assert_strobe_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rd_no || !ext_wr_no) |-> !ext_ce_no);
endmodule

bind brom_burst_seq brom_burst_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_brom_burst_seq.sv
module sim_brom_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_burst_en_i = 1'b1, cfg_burst8_i = 1'b0;
  logic [2:0]  cfg_first_wait_i = 3'd0;
  logic [1:0]  cfg_beat_wait_i = 2'd0;
  logic        req_i = 1'b0, req_we_i = 1'b0, req_word_i = 1'b0, req_fetch_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_done_o;
  logic [31:0] rsp_data_o;
  logic [22:0] ext_haddr_o;
  logic        ext_ce_no, ext_rd_no, ext_wr_no;
  logic        ext_wait_ni = 1'b1;
  logic [15:0] ext_data_i = '0;
  logic [15:0] ext_data_o;
  logic        ext_data_oe_o;

  brom_burst_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_burst_en_i(cfg_burst_en_i), .cfg_burst8_i(cfg_burst8_i),
    .cfg_first_wait_i(cfg_first_wait_i), .cfg_beat_wait_i(cfg_beat_wait_i),
    .req_i(req_i), .req_we_i(req_we_i), .req_word_i(req_word_i), .req_fetch_i(req_fetch_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .rsp_done_o(rsp_done_o), .rsp_data_o(rsp_data_o),
    .ext_haddr_o(ext_haddr_o), .ext_ce_no(ext_ce_no), .ext_rd_no(ext_rd_no),
    .ext_wr_no(ext_wr_no), .ext_wait_ni(ext_wait_ni), .ext_data_i(ext_data_i),
    .ext_data_o(ext_data_o), .ext_data_oe_o(ext_data_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  // reference model state: the bus is either idle or in its done cycle
  bit          in_done = 0, done_rd = 0, last_rdb = 0, last_fetch = 0;
  logic [31:0] done_data = '0;
  logic [22:0] last_h = '0;

  task automatic step(input bit e_ce, input bit e_rd, input bit e_wr, input bit e_done,
                      input bit a_v, input logic [22:0] e_a, input bit d_v,
                      input logic [31:0] e_d, input logic [15:0] e_wd, input string tag);
    bit ok;
    #1;
    n_chk++;
    ok = (ext_ce_no == e_ce) && (ext_rd_no == e_rd) && (ext_wr_no == e_wr) &&
         (rsp_done_o == e_done) && (ext_data_oe_o == !e_wr) &&
         (!a_v || ext_haddr_o == e_a) && (!d_v || rsp_data_o == e_d) &&
         (e_wr || ext_data_o == e_wd);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: ce rd wr done oe=%b%b%b%b%b addr=%h rsp=%h dout=%h, expected %b%b%b%b%b addr=%h rsp=%h dout=%h",
               tag, ext_ce_no, ext_rd_no, ext_wr_no, rsp_done_o, ext_data_oe_o, ext_haddr_o,
               rsp_data_o, ext_data_o, e_ce, e_rd, e_wr, e_done, !e_wr, e_a, e_d, e_wd);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit exp_cont(input logic [23:0] addr, input bit word, input bit fetch,
                                  input bit we);
    bit edge_hit;
    edge_hit = cfg_burst8_i ? (last_h[2:0] == 3'b111) : (last_h[1:0] == 2'b11);
    return in_done && cfg_burst_en_i && last_rdb && last_fetch && fetch && !we &&
           !(word && addr[1]) && (addr[23:1] == 23'(last_h + 23'd1)) && !edge_hit;
  endfunction

  task automatic run(input logic [23:0] addr, input bit word, input bit fetch, input bit we,
                     input logic [31:0] wd, input logic [15:0] d0, input logic [15:0] d1,
                     input int stretch, input bit pin_low, input string tag);
    bit c, rdb;
    logic [22:0] h;
    int w, nb, total;
    c = exp_cont(addr, word, fetch, we);
    req_i = 1; req_addr_i = addr; req_word_i = word; req_fetch_i = fetch;
    req_we_i = we; req_wdata_i = wd; ext_wait_ni = 1;
    if (in_done) begin
      step(0, !done_rd, 1, 1, 0, '0, done_rd, done_data, '0, tag);
      if (!c) step(1, 1, 1, 0, 0, '0, 0, '0, '0, tag);
    end else begin
      step(1, 1, 1, 0, 0, '0, 0, '0, '0, tag);
    end
    req_i = 0;
    rdb = cfg_burst_en_i && !we;
    h  = word ? {addr[23:2], 1'b0} : addr[23:1];
    nb = word ? 2 : 1;
    for (int b = 0; b < nb; b++) begin
      if (b == 0) w = c ? int'(cfg_beat_wait_i) : int'(cfg_first_wait_i);
      else        w = rdb ? int'(cfg_beat_wait_i) : int'(cfg_first_wait_i);
      total = w + 1 + (rdb ? 0 : stretch);
      for (int k = 0; k < total; k++) begin
        ext_data_i = (k == total - 1) ? ((b == 1) ? d1 : d0) : (16'hA5A5 ^ 16'(k));
        if (rdb) ext_wait_ni = !pin_low;
        else     ext_wait_ni = !(k >= w && k < total - 1);
        step(0, we, !we, 0, 1, 23'(h + 23'(b)), 0, '0,
             (b == 1) ? wd[31:16] : wd[15:0], tag);
      end
    end
    ext_wait_ni = 1;
    in_done = 1; done_rd = !we;
    done_data = word ? {d1, d0} : {16'h0000, d0};
    last_h = 23'(h + 23'(nb - 1)); last_rdb = rdb; last_fetch = fetch;
  endtask

  task automatic finish(input string tag);
    if (in_done) begin
      req_i = 0;
      step(0, !done_rd, 1, 1, 0, '0, done_rd, done_data, '0, tag);
      in_done = 0;
      step(1, 1, 1, 0, 0, '0, 0, '0, '0, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_chk++;
    if (!(ext_ce_no && ext_rd_no && ext_wr_no && !rsp_done_o && !ext_data_oe_o && req_ready_o)) begin
      n_bad++;
      $display("FAIL R1: ce rd wr done oe ready=%b%b%b%b%b%b, expected 111001",
               ext_ce_no, ext_rd_no, ext_wr_no, rsp_done_o, ext_data_oe_o, req_ready_o);
    end
    @(negedge clk);
    rst_ni = 1;

    // R2: first-access wait, capture on last cycle only
    cfg_burst_en_i = 1; cfg_burst8_i = 0; cfg_first_wait_i = 3; cfg_beat_wait_i = 1;
    run(24'h001000, 0, 0, 0, '0, 16'h1234, '0, 0, 0, "R2 first beat");
    finish("R2 release");
    cfg_first_wait_i = 0;
    run(24'h001002, 0, 0, 0, '0, 16'h0F0F, '0, 0, 0, "R2 zero wait");
    finish("R2 zero wait");

    // R3 R4: word read with wait pin held low
    cfg_first_wait_i = 2; cfg_beat_wait_i = 1;
    run(24'h001008, 1, 0, 0, '0, 16'h5678, 16'h9ABC, 0, 1, "R3 R4 word burst");
    finish("R3 R4 word done");

    // R6 R7 R8: 4-beat fetch run, boundary, then break
    cfg_first_wait_i = 2; cfg_beat_wait_i = 2;
    run(24'h002000, 0, 1, 0, '0, 16'h1000, '0, 0, 1, "R6 fetch h0");
    run(24'h002002, 0, 1, 0, '0, 16'h1001, '0, 0, 1, "R6 fetch h1");
    run(24'h002004, 0, 1, 0, '0, 16'h1002, '0, 0, 0, "R6 fetch h2");
    run(24'h002006, 0, 1, 0, '0, 16'h1003, '0, 0, 0, "R6 fetch h3");
    run(24'h002008, 0, 1, 0, '0, 16'h1004, '0, 0, 0, "R7 4-beat edge");
    run(24'h00200C, 0, 1, 0, '0, 16'h1005, '0, 0, 0, "R8 non-contiguous");
    finish("R9 release");

    // R6: word fetch continuation; R8: data read is not continued
    cfg_beat_wait_i = 0;
    run(24'h003000, 1, 1, 0, '0, 16'h2000, 16'h2001, 0, 0, "R6 word fetch");
    run(24'h003004, 1, 1, 0, '0, 16'h2002, 16'h2003, 0, 0, "R6 word fetch cont");
    finish("R6 word end");
    run(24'h003010, 1, 0, 0, '0, 16'h2100, 16'h2101, 0, 0, "R8 data word");
    run(24'h003014, 0, 1, 0, '0, 16'h2102, '0, 0, 0, "R8 fetch after data");
    finish("R8 end");

    // R7: 8-beat mode
    cfg_burst8_i = 1; cfg_first_wait_i = 1; cfg_beat_wait_i = 0;
    run(24'h004006, 0, 1, 0, '0, 16'h3003, '0, 0, 0, "R7 8-beat h3");
    run(24'h004008, 0, 1, 0, '0, 16'h3004, '0, 0, 0, "R7 8-beat crosses 4 group");
    run(24'h00400A, 0, 1, 0, '0, 16'h3005, '0, 0, 0, "R7 8-beat h5");
    run(24'h00400C, 0, 1, 0, '0, 16'h3006, '0, 0, 0, "R7 8-beat h6");
    run(24'h00400E, 0, 1, 0, '0, 16'h3007, '0, 0, 0, "R7 8-beat h7");
    run(24'h004010, 0, 1, 0, '0, 16'h3008, '0, 0, 0, "R7 8-beat edge");
    finish("R7 end");

    // R5: writes stretched by wait pin
    cfg_burst8_i = 0; cfg_first_wait_i = 2; cfg_beat_wait_i = 1;
    run(24'h005000, 0, 0, 1, 32'h0000BEEF, '0, '0, 2, 0, "R5 half write");
    finish("R5 half end");
    run(24'h005004, 1, 0, 1, 32'hCAFEF00D, '0, '0, 1, 0, "R5 word write");
    run(24'h005008, 0, 1, 0, '0, 16'h4444, '0, 0, 0, "R8 fetch after write");
    finish("R5 end");

    // R10: burst mode off
    cfg_burst_en_i = 0; cfg_first_wait_i = 1; cfg_beat_wait_i = 3;
    run(24'h006000, 1, 1, 0, '0, 16'h5000, 16'h5001, 2, 0, "R10 word read stretched");
    run(24'h006004, 0, 1, 0, '0, 16'h5002, '0, 0, 0, "R10 no continuation");
    finish("R10 end");

    fin = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: got no completion, expected end of sequence");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule